// File: doc/BRIEF.md
# Dual-Plane Permutation Switch

This block routes N data ports (N a power of two) to N outputs through any permutation. The permutation is set by control bits supplied from outside. Each plane is a complete permutation network: two omega networks in cascade, which gives 2·log2 N stages of N/2 two-by-two exchange elements. Before every stage there is a perfect-shuffle wiring. A single omega network cannot realise every permutation, but two in sequence can, and the hardware still grows as N log N.

Two identical planes are built. One plane carries traffic. The other is a standby plane that takes a new configuration one stage word at a time. The new words have no effect on the output until a commit strobe is accepted. At the commit the output selector moves to the standby plane. The old plane is released for writing one cycle later, so the new path is in place before the old one is broken. Computing the route is done elsewhere. Many-to-many connections are not supported.

Top module: `dp_perm_switch`

## Requirements
- R1: While rst_ni is low, and until the first clock edge after release, active_plane_o, busy_o, ready_o and data_o are all 0. Both planes hold all-zero configuration, so they route input port i to output port i.
- R2: An element whose control bit is 0 passes its upper input to its upper output and its lower input to its lower output. An element whose control bit is 1 swaps them. Before each stage, line i moves to line rotl(i): the log2 N-bit index rotated left by one.
- R3: A plane has S = 2·log2 N stages, and stage k = 0 is nearest the inputs. Bit e of stage k's word controls the element on lines 2e and 2e+1 of that stage.
- R4: Configuration words are written only into the standby plane. While active_plane_o does not change, data_o keeps following the active plane's configuration.
- R5: Each accepted cfg_we_i writes cfg_word_i to the next stage of the standby plane, in order 0 to S-1. busy_o is 1 after 1 to S-1 words of a load have been accepted.
- R6: At the clock edge that accepts word S-1, ready_o becomes 1 and busy_o becomes 0.
- R7: A commit is accepted only when commit_i is 1, busy_o is 0 and ready_o is 1. An accepted commit toggles active_plane_o at that edge and clears ready_o. Any other commit_i has no effect.
- R8: data_o is registered from the plane selected before the edge. It shows the new plane's routing one cycle after an accepted commit.
- R9: A cfg_we_i in the cycle of an accepted commit, or in the cycle just after it, is ignored and does not advance the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | N*W | Input ports, port i at bits [i*W +: W] |
| data_o | output | N*W | Output ports, registered |
| cfg_we_i | input | 1 | Write one stage word into the standby plane |
| cfg_word_i | input | N/2 | Element control bits for the next stage |
| commit_i | input | 1 | Request switch-over to the standby plane |
| busy_o | output | 1 | Load partly written |
| ready_o | output | 1 | Standby plane fully loaded and not yet committed |
| active_plane_o | output | 1 | Index of the plane driving data_o |

## Verification
The assertions are checked on every cycle. They cover four behaviours: the active plane changes only through an accepted commit, busy and ready are never high together, ready rises only from an active load, and the active plane's configuration never changes while it carries traffic. No write is taken in the cycle that follows a switch-over. Two things can only be shown by the bench's scenarios. One is that the shuffle wiring and the element settings give the right permutation for each configuration pattern. The other is the one-cycle lag of data_o behind a commit, together with ignored writes and refused commits, seen at the ports.

// File: rtl/dpps_pkg.sv
package dpps_pkg;
  // perfect shuffle: rotate lg-bit index left by one
  function automatic int shuf_idx(input int i, input int lg);
    return ((i << 1) | (i >> (lg - 1))) & ((1 << lg) - 1);
  endfunction
endpackage

// File: rtl/dpps_elem.sv
module dpps_elem #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cross_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  always_comb begin
    if (cross_i) begin
      a_o = b_i;
      b_o = a_i;
    end else begin
      a_o = a_i;
      b_o = b_i;
    end
  end
endmodule

// File: rtl/dpps_stage.sv
module dpps_stage #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0] d_i,
  input  logic [N/2-1:0] ctl_i,
  output logic [N*W-1:0] d_o
);
  localparam int LG = $clog2(N);
  logic [N*W-1:0] sh;

  for (genvar i = 0; i < N; i++) begin : g_shuf
    assign sh[dpps_pkg::shuf_idx(i, LG)*W +: W] = d_i[i*W +: W];
  end

  for (genvar e = 0; e < N/2; e++) begin : g_elem
    dpps_elem #(.W(W)) u_elem (
      .a_i    (sh[(2*e)*W +: W]),
      .b_i    (sh[(2*e+1)*W +: W]),
      .cross_i(ctl_i[e]),
      .a_o    (d_o[(2*e)*W +: W]),
      .b_o    (d_o[(2*e+1)*W +: W])
    );
  end
endmodule

// File: rtl/dpps_plane.sv
module dpps_plane #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LG = $clog2(N),
  localparam int S = 2*LG,
  localparam int HALF = N/2
) (
  input  logic [S*HALF-1:0] cfg_i,
  input  logic [N*W-1:0]    d_i,
  output logic [N*W-1:0]    d_o
);
  logic [N*W-1:0] lvl [S+1];
  assign lvl[0] = d_i;

  // first LG stages form one omega network, the next LG a second one
  for (genvar k = 0; k < S; k++) begin : g_stage
    dpps_stage #(.N(N), .W(W)) u_stage (
      .d_i  (lvl[k]),
      .ctl_i(cfg_i[k*HALF +: HALF]),
      .d_o  (lvl[k+1])
    );
  end

  assign d_o = lvl[S];
endmodule

// File: rtl/dpps_ctrl.sv
module dpps_ctrl #(
  parameter int S = 6,
  localparam int CW = (S > 1) ? $clog2(S) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          commit_i,
  output logic          busy_o,
  output logic          ready_o,
  output logic          active_o,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_stage_o
);
  localparam logic [CW-1:0] LAST = CW'(S - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q, active_q, free_q;
  logic          commit_acc;

  assign busy_o     = (cnt_q != '0);
  assign ready_o    = ready_q;
  assign active_o   = active_q;
  assign commit_acc = commit_i && !busy_o && ready_q;
  // commit wins over a write; old plane is writable only once released
  assign wr_en_o    = we_i && free_q && !commit_acc;
  assign wr_stage_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ready_q  <= 1'b0;
      active_q <= 1'b0;
      free_q   <= 1'b1;
    end else begin
      if (commit_acc) begin
        active_q <= ~active_q;
        ready_q  <= 1'b0;
        free_q   <= 1'b0;
      end else begin
        free_q <= 1'b1;
        if (wr_en_o) begin
          cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          ready_q <= (cnt_q == LAST);
        end
      end
    end
  end

  a_r7_toggle_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q != $past(active_q)) |-> $past(commit_i && !busy_o && ready_o));
  a_r5_busy_excl_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ready_o);
  a_r6_ready_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(busy_o || S == 1));
  a_r9_hold_after_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q != $past(active_q)) |-> !wr_en_o);
endmodule

// File: rtl/dp_perm_switch.sv
module dp_perm_switch #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LG = $clog2(N),
  localparam int S = 2*LG,
  localparam int HALF = N/2,
  localparam int CW = (S > 1) ? $clog2(S) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N*W-1:0]  data_i,
  output logic [N*W-1:0]  data_o,
  input  logic            cfg_we_i,
  input  logic [HALF-1:0] cfg_word_i,
  input  logic            commit_i,
  output logic            busy_o,
  output logic            ready_o,
  output logic            active_plane_o
);
  logic            wr_en, active;
  logic [CW-1:0]   wr_stage;
  logic [S*HALF-1:0] cfg_q [2];
  logic [N*W-1:0]  pl_out [2];
  logic [S*HALF-1:0] act_cfg;

  dpps_ctrl #(.S(S)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .commit_i  (commit_i),
    .busy_o    (busy_o),
    .ready_o   (ready_o),
    .active_o  (active),
    .wr_en_o   (wr_en),
    .wr_stage_o(wr_stage)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q[0] <= '0;
      cfg_q[1] <= '0;
    end else if (wr_en) begin
      cfg_q[~active][int'(wr_stage)*HALF +: HALF] <= cfg_word_i;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_plane
    dpps_plane #(.N(N), .W(W)) u_plane (
      .cfg_i(cfg_q[p]),
      .d_i  (data_i),
      .d_o  (pl_out[p])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= pl_out[active];
  end

  assign active_plane_o = active;
  assign act_cfg        = cfg_q[active];

  a_r4_live_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active == $past(active)) |-> $stable(act_cfg));
endmodule

// File: tb/test_dp_perm_switch.sv
module test_dp_perm_switch;
  localparam int N = 8, W = 8, LG = 3, S = 6, HALF = 4;
  localparam int NT = 6;
  localparam logic [S*HALF-1:0] TBL [NT] = '{
    24'hFFFFFF, 24'h0F0F0F, 24'hA5C3E1, 24'h123456, 24'h000001, 24'h800000
  };

  logic clk = 0, rst_ni = 0;
  logic [N*W-1:0] data_i = '0, data_o;
  logic cfg_we = 0, commit = 0;
  logic [HALF-1:0] cfg_word = '0;
  logic busy, ready, act;
  int total = 0, fails = 0;
  logic [S*HALF-1:0] cur_cfg = '0;
  logic exp_act = 0;

  always #10 clk = ~clk;

  dp_perm_switch #(.N(N), .W(W)) i_dp_perm_switch (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .data_o(data_o),
    .cfg_we_i(cfg_we), .cfg_word_i(cfg_word), .commit_i(commit),
    .busy_o(busy), .ready_o(ready), .active_plane_o(act)
  );

  function automatic logic [N*W-1:0] model(input logic [S*HALF-1:0] c,
                                           input logic [N*W-1:0] d);
    logic [W-1:0] x [N];
    logic [W-1:0] y [N];
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) x[i] = d[i*W +: W];
    for (int s = 0; s < S; s++) begin
      for (int i = 0; i < N; i++) y[((i << 1) | (i >> (LG-1))) & (N-1)] = x[i];
      for (int e = 0; e < HALF; e++) begin
        if (c[s*HALF+e]) begin x[2*e] = y[2*e+1]; x[2*e+1] = y[2*e]; end
        else             begin x[2*e] = y[2*e];   x[2*e+1] = y[2*e+1]; end
      end
    end
    for (int i = 0; i < N; i++) r[i*W +: W] = x[i];
    return r;
  endfunction

  function automatic logic [N*W-1:0] pattern(input int t);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(t*37 + i*13 + 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [N*W-1:0] a, input logic [N*W-1:0] e);
    total++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic wr(input logic [HALF-1:0] w);
    cfg_we = 1; cfg_word = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_commit();
    commit = 1;
    @(negedge clk);
    commit = 0;
  endtask

  task automatic load(input logic [S*HALF-1:0] c);
    for (int k = 0; k < S; k++) begin
      wr(c[k*HALF +: HALF]);
      if (k < S-1) chk("R5 busy mid-load", 64'(busy), 64'(1));
    end
    chk("R6 ready after last word", 64'({busy, ready}), 64'(2'b01));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    data_i = pattern(99);
    #35;
    chk("R1 reset outputs", {61'(data_o), act, busy, ready}, '0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 identity after reset", data_o, data_i);

    // vector walk: load, verify hold, commit, verify lag and new route
    for (int t = 0; t < NT; t++) begin
      data_i = pattern(t);
      load(TBL[t]);
      @(negedge clk);
      chk("R4 standby load not visible", data_o, model(cur_cfg, data_i));
      do_commit();
      exp_act = ~exp_act;
      chk("R7 commit switches plane", 64'(act), 64'(exp_act));
      chk("R8 output lags commit", data_o, model(cur_cfg, data_i));
      cur_cfg = TBL[t];
      @(negedge clk);
      chk("R2 R3 route matches config", data_o, model(cur_cfg, data_i));
    end

    // R9: write right after a commit is dropped
    data_i = pattern(50);
    load(24'h5A5A5A);
    do_commit();
    exp_act = ~exp_act;
    cur_cfg = 24'h5A5A5A;
    wr(4'hF);
    chk("R9 write after commit ignored", 64'(busy), 64'(0));

    // R7: commit while not ready refused
    do_commit();
    chk("R7 commit refused not ready", 64'(act), 64'(exp_act));

    // R7: commit while busy refused, load then completes normally
    wr(4'h3); wr(4'hC);
    do_commit();
    chk("R7 commit refused while busy", 64'({act, busy}), 64'({exp_act, 1'b1}));
    wr(4'h6); wr(4'h9); wr(4'h1); wr(4'h8);
    chk("R6 ready after resumed load", 64'(ready), 64'(1));
    do_commit();
    exp_act = ~exp_act;
    cur_cfg = 24'h8196C3;
    @(negedge clk);
    chk("R9 R5 load order intact", data_o, model(cur_cfg, data_i));

    // R9: write in the commit cycle itself is dropped
    load(24'h000000);
    cfg_we = 1; cfg_word = 4'h7; commit = 1;
    @(negedge clk);
    cfg_we = 0; commit = 0;
    exp_act = ~exp_act;
    cur_cfg = '0;
    @(negedge clk);
    chk("R9 write in commit cycle dropped", 64'({act, busy}), 64'({exp_act, 1'b0}));
    chk("R1 R2 zero config identity", data_o, data_i);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule